// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side serial front end of a 512-byte nonvolatile memory model. It runs on a fast system clock and oversamples the four serial lines: chip select, serial clock, serial data in and pause. It shifts in an 8-bit instruction, decodes it, and assembles a 9-bit byte address from one opcode bit and the following address byte. It then either streams array or status bytes out MSB first, or turns incoming bytes into requests for a separate write/protect controller.

Array contents are fetched through a synchronous read port: `rd_en` with `rd_addr` in one system cycle gives `rd_data` in the next. The status byte is supplied live by the controller on `status_in`. Requests leave through a single-entry valid/ready slot. A request that is offered while the controller is not ready stays in place, unchanged, until `req_ready` is high. The serial bus cannot be stalled, so an event that completes while the slot is still occupied is dropped. The controller must therefore drain the slot within one serial byte time if it wants to see every event.

Top module: `spi_mem_frontend`

## Requirements
- R1: Bits on `si` are captured on falling `sck` edges, MSB first. Opcode 0x06 issues a request of kind 0 (set write enable) and opcode 0x04 issues kind 1 (clear write enable).
- R2: For the array opcodes, bit 3 of the opcode byte is masked during decode (0x03/0x0B read, 0x02/0x0A write) and becomes address bit 8. The next byte supplies address bits 7..0.
- R3: During an array read, `so` changes only after rising `sck` edges. The first rising edge after the address byte presents bit 7 of the byte at the captured address.
- R4: A sequential read advances the address by one after each byte and wraps from 0x1FF to 0x000.
- R5: Opcode 0x05 shifts out `status_in` MSB first. The byte repeats for as long as clocks continue, and this works regardless of any write activity.
- R6: After a write opcode and its address, each complete data byte issues a kind 3 request carrying the current address and the byte. The address then advances within its aligned 4-byte page, so its low 2 bits wrap.
- R7: After opcode 0x01, the first complete byte issues a kind 2 request carrying that byte. Further bytes are ignored.
- R8: While `cs_n` is high, `so_oe` is 0 and any partly received byte or sequence is discarded. Each rising edge of `cs_n` after arming issues a kind 4 (deselect) request.
- R9: After reset, nothing is decoded and no request is issued until `cs_n` has made a high-to-low transition.
- R10: Taking `hold_n` low while `sck` is high pauses the transfer. During the pause `so_oe` is 0, and `sck`/`si` activity has no effect. Releasing `hold_n` while `sck` is high resumes at the exact bit that was paused.
- R11: An opcode not listed above produces no request, and the rest of the sequence is ignored until `cs_n` goes high.
- R12: While `req_valid` is high and `req_ready` is low, the request fields hold steady. An event arriving in that state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | 9 | Array read address |
| rd_data | input | 8 | Array read data, valid the cycle after `rd_en` |
| status_in | input | 8 | Current status byte from the controller |
| req_valid | output | 1 | Request slot occupied |
| req_ready | input | 1 | Controller accepts the request |
| req_kind | output | 3 | 0 set-enable, 1 clear-enable, 2 status write, 3 data byte, 4 deselect |
| req_addr | output | 9 | Address of a data-byte request |
| req_data | output | 8 | Data byte of a data-byte or status-write request |

## Verification
The assertions assume that `cs_n` only changes while `sck` is low, that `hold_n` changes only while `sck` is high, and that every serial level is held for at least two system cycles. Under those conditions the synchronizers and edge detectors see each transition exactly once. The stimulus keeps every serial half period at eight system cycles. It toggles `hold_n` only inside a high phase of `sck`, and it moves `cs_n` only after `sck` has been low for a full half period. Opcodes, addresses and data bytes are drawn at random, and the wrap, hold, back-pressure and partial-byte cases are driven directly.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int ADDR_W = 9;

  localparam logic [7:0] OPC_SET_EN  = 8'h06;
  localparam logic [7:0] OPC_CLR_EN  = 8'h04;
  localparam logic [7:0] OPC_RD_STAT = 8'h05;
  localparam logic [7:0] OPC_WR_STAT = 8'h01;
  localparam logic [7:0] OPC_RD_ARR  = 8'h03;
  localparam logic [7:0] OPC_WR_ARR  = 8'h02;
  localparam logic [7:0] OPC_HI_MASK = 8'hF7;

  typedef enum logic [2:0] {
    REQ_EN_SET  = 3'd0,
    REQ_EN_CLR  = 3'd1,
    REQ_STAT_WR = 3'd2,
    REQ_DATA    = 3'd3,
    REQ_DESEL   = 3'd4
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_WDATA, PH_SDATA, PH_OUT, PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_fe_req_slot.sv
module spi_fe_req_slot #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic [2:0]    ev_kind,
  input  logic [AW-1:0] ev_addr,
  input  logic [7:0]    ev_data,
  input  logic          ready,
  output logic          valid,
  output logic [2:0]    kind,
  output logic [AW-1:0] addr,
  output logic [7:0]    data
);
  logic take;
  assign take = ev && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= '0;
      addr  <= '0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      kind  <= ev_kind;
      addr  <= ev_addr;
      data  <= ev_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [7:0]        status_in,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  localparam logic [ADDR_W-1:0] A_ONE  = 1;
  localparam logic [PAGE_W-1:0] PG_ONE = 1;

  // synchronized lines: {hold_n, cs_n, sck, si}; cs resets "selected" so a
  // low chip select at reset never looks like a fresh falling edge
  logic [3:0] syn;
  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hold_n, cs_n, sck, si}), .q(syn)
  );
  logic hold_s, cs_s, sck_s, si_s;
  assign {hold_s, cs_s, sck_s, si_s} = syn;

  logic sck_d, cs_d, armed, hold_q;
  logic sel, active, sck_fall, sck_rise, cs_rise, cs_fall;
  phase_e phase;
  logic [2:0] bitcnt, ocnt;
  logic [6:0] shreg;
  logic [7:0] out_sr, in_byte;
  logic [ADDR_W-1:0] addr;
  logic a8, is_read, so_q, ld_q, byte_done;

  assign sel      = armed & ~cs_s;
  assign active   = sel & ~hold_q;
  assign sck_fall = active & sck_d & ~sck_s;
  assign sck_rise = active & ~sck_d & sck_s;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign in_byte  = {shreg, si_s};
  assign byte_done = sck_fall && (bitcnt == 3'd7);

  // request events and array read strobe
  logic ev;
  logic [2:0] ev_kind;
  logic [ADDR_W-1:0] ev_addr;
  always_comb begin
    ev = 1'b0;
    ev_kind = REQ_DESEL;
    ev_addr = addr;
    rd_en = 1'b0;
    rd_addr = addr;
    if (cs_rise && armed) ev = 1'b1;
    if (byte_done) begin
      unique case (phase)
        PH_OPC: begin
          if (in_byte == OPC_SET_EN) begin ev = 1'b1; ev_kind = REQ_EN_SET; end
          else if (in_byte == OPC_CLR_EN) begin ev = 1'b1; ev_kind = REQ_EN_CLR; end
        end
        PH_ADDR: if (is_read) begin
          rd_en = 1'b1;
          rd_addr = {a8, in_byte};
        end
        PH_WDATA: begin ev = 1'b1; ev_kind = REQ_DATA; end
        PH_SDATA: begin ev = 1'b1; ev_kind = REQ_STAT_WR; end
        default: ;
      endcase
    end
    if (sck_rise && phase == PH_OUT && ocnt == 3'd7 && is_read) begin
      rd_en = 1'b1;
      rd_addr = addr + A_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b0; armed <= 1'b0; hold_q <= 1'b0;
      phase <= PH_OPC; bitcnt <= '0; ocnt <= '0; shreg <= '0;
      out_sr <= '0; addr <= '0; a8 <= 1'b0; is_read <= 1'b0;
      so_q <= 1'b0; ld_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      ld_q  <= rd_en;
      if (cs_fall) armed <= 1'b1;
      if (cs_s) begin
        phase <= PH_OPC; bitcnt <= '0; ocnt <= '0; hold_q <= 1'b0;
      end else begin
        if (sel && sck_s) hold_q <= ~hold_s;
        if (sck_fall) begin
          shreg  <= in_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            unique case (phase)
              PH_OPC: begin
                ocnt <= '0;
                if (in_byte == OPC_RD_STAT) begin
                  is_read <= 1'b0; out_sr <= status_in; phase <= PH_OUT;
                end else if (in_byte == OPC_WR_STAT) begin
                  phase <= PH_SDATA;
                end else if ((in_byte & OPC_HI_MASK) == OPC_RD_ARR) begin
                  a8 <= in_byte[3]; is_read <= 1'b1; phase <= PH_ADDR;
                end else if ((in_byte & OPC_HI_MASK) == OPC_WR_ARR) begin
                  a8 <= in_byte[3]; is_read <= 1'b0; phase <= PH_ADDR;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_ADDR: begin
                addr  <= {a8, in_byte};
                phase <= is_read ? PH_OUT : PH_WDATA;
              end
              PH_WDATA: addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
              PH_SDATA: phase <= PH_SKIP;
              default: ;
            endcase
          end
        end
        if (sck_rise && phase == PH_OUT) begin
          so_q <= out_sr[7];
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd7) begin
            if (is_read) addr <= addr + A_ONE;
            else out_sr <= status_in;
          end else begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end else if (ld_q) begin
          out_sr <= rd_data;
        end
      end
    end
  end

  assign so    = so_q;
  assign so_oe = sel & ~hold_q;

  spi_fe_req_slot #(.AW(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_data(in_byte), .ready(req_ready), .valid(req_valid), .kind(req_kind),
    .addr(req_addr), .data(req_data)
  );
endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so,
  input logic       so_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_kind,
  input logic [8:0] req_addr,
  input logic [7:0] req_data,
  input logic       armed,
  input logic       hold_q
);
  // R8: a chip select held high through the synchronizer leaves SO undriven
  assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

  // R12: a stalled request keeps every field
  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind)
      && $stable(req_addr) && $stable(req_data)));

  // R9: nothing is requested before the first chip-select falling edge
  assert_no_req_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !req_valid);

  // R10: a paused transfer freezes the output bit
  assert_hold_so_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> $stable(so));
endmodule

bind spi_mem_frontend spi_mem_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
  .req_addr(req_addr), .req_data(req_data), .armed(armed), .hold_q(hold_q)
);

// File: tb/sim_spi_mem_frontend.sv
module sim_spi_mem_frontend;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n;
  logic so, so_oe, rd_en, req_valid, req_ready;
  logic [8:0] rd_addr, req_addr;
  logic [7:0] rd_data, status_in, req_data;
  logic [2:0] req_kind;

  int checks = 0, fails = 0;
  int rq_n = 0;
  logic [2:0] rq_kind [64];
  logic [8:0] rq_addr [64];
  logic [7:0] rq_data [64];

  always #2 clk = ~clk;

  spi_mem_frontend u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data)
  );

  function automatic logic [7:0] mem_val(input logic [8:0] a);
    return a[7:0] ^ 8'h35 ^ {a[8], 7'b0};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_val(rd_addr);

  always @(negedge clk)
    if (rst_n && req_valid && req_ready && rq_n < 64) begin
      rq_kind[rq_n] = req_kind;
      rq_addr[rq_n] = req_addr;
      rq_data[rq_n] = req_data;
      rq_n++;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sel_dev();
    cs_n = 1'b0; tick(H);
  endtask

  task automatic desel_dev();
    sck = 1'b0; tick(H);
    cs_n = 1'b1; tick(3 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i]; sck = 1'b1; tick(H);
      if (i == hold_at) begin
        hold_n = 1'b0; tick(H);
        check(so_oe == 1'b0, "R10 so_oe during pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b0; si = ~si; tick(H);
          sck = 1'b1; tick(H);
        end
        si = tx[i]; hold_n = 1'b1; tick(H);
      end
      rx[i] = so;
      sck = 1'b0; tick(H);
    end
  endtask

  task automatic expect_req(input int idx, input logic [2:0] k, input logic [8:0] a,
                            input logic [7:0] d, input bit full, input string tag);
    check(rq_kind[idx] == k, {tag, " kind"}, rq_kind[idx], k);
    if (full) begin
      check(rq_addr[idx] == a, {tag, " addr"}, rq_addr[idx], a);
      check(rq_data[idx] == d, {tag, " data"}, rq_data[idx], d);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx, rx2, st, dv [5];
    logic [8:0] a;
    int base, n;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    req_ready = 1'b1; status_in = 8'h00;
    tick(10);
    check(so_oe == 1'b0, "R8 reset so_oe", so_oe, 0);
    check(req_valid == 1'b0, "R8 reset req_valid", req_valid, 0);
    rst_n = 1'b1; tick(10);

    // R9: chip select already low at reset, no fresh falling edge
    base = rq_n;
    xfer(8'h06, -1, rx);
    desel_dev();
    check(rq_n - base == 0, "R9 unarmed requests", rq_n - base, 0);

    // R1: set and clear enable
    base = rq_n; sel_dev(); xfer(8'h06, -1, rx); desel_dev();
    check(rq_n - base == 2, "R1 set-enable count", rq_n - base, 2);
    expect_req(base, 3'd0, 0, 0, 0, "R1 set-enable");
    expect_req(base + 1, 3'd4, 0, 0, 0, "R8 deselect");
    base = rq_n; sel_dev(); xfer(8'h04, -1, rx); desel_dev();
    check(rq_n - base == 2, "R1 clear-enable count", rq_n - base, 2);
    expect_req(base, 3'd1, 0, 0, 0, "R1 clear-enable");

    // R5: status read repeats
    st = 8'($urandom); status_in = st;
    base = rq_n; sel_dev(); xfer(8'h05, -1, rx); xfer(8'h00, -1, rx); xfer(8'hFF, -1, rx2);
    desel_dev();
    check(rx == st, "R5 status byte", rx, st);
    check(rx2 == st, "R5 status repeat", rx2, st);
    check(rq_n - base == 1, "R5 only deselect", rq_n - base, 1);

    // R2 R3 R4: array reads, first one crossing the top of the space
    for (int t = 0; t < 6; t++) begin
      a = (t == 0) ? 9'h1FD : 9'($urandom);
      n = (t == 0) ? 5 : 2 + int'($urandom % 3);
      sel_dev();
      xfer({4'b0000, a[8], 3'b011}, -1, rx);
      xfer(a[7:0], -1, rx);
      for (int k = 0; k < n; k++) begin
        xfer(8'($urandom), -1, rx);
        check(rx == mem_val(a + 9'(k)), "R3 R4 R2 read byte", rx, mem_val(a + 9'(k)));
      end
      desel_dev();
    end

    // R6: write burst wrapping inside a 4-byte page
    base = rq_n; sel_dev(); xfer(8'h0A, -1, rx); xfer(8'hFE, -1, rx);
    for (int k = 0; k < 5; k++) begin dv[k] = 8'($urandom); xfer(dv[k], -1, rx); end
    desel_dev();
    check(rq_n - base == 6, "R6 request count", rq_n - base, 6);
    expect_req(base,     3'd3, 9'h1FE, dv[0], 1, "R6 byte0");
    expect_req(base + 1, 3'd3, 9'h1FF, dv[1], 1, "R6 byte1");
    expect_req(base + 2, 3'd3, 9'h1FC, dv[2], 1, "R6 byte2 page wrap");
    expect_req(base + 4, 3'd3, 9'h1FE, dv[4], 1, "R6 byte4");

    // R7: status write keeps only the first byte
    base = rq_n; sel_dev(); xfer(8'h01, -1, rx); xfer(8'h0C, -1, rx); xfer(8'h55, -1, rx);
    desel_dev();
    check(rq_n - base == 2, "R7 request count", rq_n - base, 2);
    expect_req(base, 3'd2, 0, 8'h0C, 0, "R7 status write");
    check(rq_data[base] == 8'h0C, "R7 status data", rq_data[base], 8'h0C);

    // R11: unknown opcode swallows the rest
    base = rq_n; sel_dev(); xfer(8'hFF, -1, rx); xfer(8'h06, -1, rx); desel_dev();
    check(rq_n - base == 1, "R11 only deselect", rq_n - base, 1);
    expect_req(base, 3'd4, 0, 0, 0, "R11 deselect");

    // R8: partial opcode discarded, idle output
    base = rq_n; sel_dev();
    for (int i = 7; i >= 4; i--) begin
      si = 1'b0; sck = 1'b1; tick(H); sck = 1'b0; tick(H);
    end
    desel_dev();
    check(so_oe == 1'b0, "R8 so_oe while deselected", so_oe, 0);
    sel_dev(); xfer(8'h04, -1, rx); desel_dev();
    check(rq_n - base == 3, "R8 partial discard count", rq_n - base, 3);
    expect_req(base + 1, 3'd1, 0, 0, 0, "R8 clean decode after partial");

    // R10: pauses inside address and data bytes
    sel_dev(); xfer(8'h03, -1, rx); xfer(8'h40, 5, rx);
    xfer(8'h00, 3, rx);
    check(rx == mem_val(9'h040), "R10 read across pause", rx, mem_val(9'h040));
    xfer(8'h00, -1, rx);
    check(rx == mem_val(9'h041), "R10 next byte after pause", rx, mem_val(9'h041));
    desel_dev();

    // R12: back-pressure holds, later event dropped
    req_ready = 1'b0; base = rq_n;
    sel_dev(); xfer(8'h06, -1, rx); desel_dev(); tick(20);
    check(req_valid == 1'b1, "R12 valid held", req_valid, 1);
    check(req_kind == 3'd0, "R12 kind held", req_kind, 0);
    req_ready = 1'b1; tick(4);
    check(rq_n - base == 1, "R12 dropped event", rq_n - base, 1);
    check(req_valid == 1'b0, "R12 slot drained", req_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule